// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Slave Wait Handshake

This block runs one external bus transfer at a time for a 16-bit processor-style master. An internal requester offers an address, write data, a direction and a per-transfer mode word. The sequencer then drives an address-latch strobe, separate active-low read and write strobes, an address/data bus and a separate address bus. It ends each transfer once a programmed number of fixed wait states has elapsed and, if the transfer is handshake-controlled, once the slave pulls the active-low `ready_n` pin low.

The slave's wait signal can be taken straight from the pin, which gives the shortest transfer. It can also be taken through a flop chain for slaves whose timing is unrelated to the bus clock; that path adds latency. In multiplexed mode, address and data share `ad_out` and a one-clock latch strobe comes first. A multiplexed transfer always closes with one settling clock. An optional bus-turnaround clock can follow in either mode. A handshake that never arrives is cut off by a timeout, and the transfer is flagged.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `err`=0 and `req_ready`=1.
- R2: `req_ready` is high only while no transfer is in progress, and during that time `ale` is low and both strobes are high. A request is taken at a rising edge where `req_valid` and `req_ready` are both high.
- R3: With `req_mux`=1, `ale` is high for exactly the one clock after acceptance, with `ad_oe`=1 and `ad_out` equal to the low DW bits of the address; the strobe follows in the next clock. With `req_mux`=0, `ale` stays low and the strobe starts in the clock right after acceptance. `addr_out` holds the accepted address in both modes.
- R4: The strobe phase drives `rd_n` low when `req_write`=0 and `wr_n` low when `req_write`=1. The two strobes are never low together.
- R5: With `req_rdy_en`=0 the strobe lasts exactly `req_wait`+1 clocks, whatever `ready_n` does.
- R6: With `req_rdy_en`=1 and `req_rdy_async`=0, the pin is sampled at the end of every strobe clock that follows the fixed waits. A high sample adds one clock and a low sample ends the strobe. If the pin goes low in strobe clock `req_wait`+D (0-based), the strobe lasts `req_wait`+D+1 clocks.
- R7: With `req_rdy_async`=1, each sample is the pin value taken two rising edges earlier. So the same stimulus gives `req_wait`+D+3 clocks. A low level left on the pin within the last two clocks before a new strobe can end that new strobe at its first sample.
- R8: With `req_mux`=1, one clock with all strobes inactive follows the strobe phase before `req_ready` returns.
- R9: With `req_trwait`=1, one more inactive clock is added. The clocks between the strobe's end and `req_ready` number 0, 1 or 2, according to `req_mux`+`req_trwait`.
- R10: In a handshake-controlled transfer, the TMO_LIM-th consecutive high sample ends the strobe and raises `err` together with `done`.
- R11: `done` is high for one clock, the clock after the last strobe clock. For a read, `rdata` then holds the `ad_in` value present at the strobe's final rising edge and keeps it until the next read completes.
- R12: During a write strobe, `ad_oe`=1 and `ad_out` equals the write data. During a read strobe, `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Sequencer idle, request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_wait | input | WAIT_W | Fixed wait states before the first handshake sample |
| req_mux | input | 1 | 1 = multiplexed address/data bus |
| req_trwait | input | 1 | Add one bus-turnaround clock after the transfer |
| req_rdy_en | input | 1 | Transfer length decided by the slave handshake |
| req_rdy_async | input | 1 | Handshake taken through the synchronizer chain |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Handshake timeout, valid with done |
| rdata | output | DW | Captured read data |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_out | output | AW | Separate address bus |
| ad_out | output | DW | Address/data bus output value |
| ad_oe | output | 1 | Address/data bus output enable |
| ad_in | input | DW | Address/data bus input value |
| ready_n | input | 1 | Slave wait handshake, active low |

## Verification
The bench builds the block with AW = DW = 16, WAIT_W = 3 and TMO_LIM = 12. With the short timeout, both the synchronous and the synchronizer-path timeouts finish within a few dozen clocks, next to ordinary handshakes. The three-bit wait field still allows fixed waits from zero to seven. Back-to-back transfers on the synchronizer path show the stale-low hazard of R7, which the behavioural model predicts clock by clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    XB_IDLE,
    XB_ALE,
    XB_CMD,
    XB_MUXW,
    XB_TRIW
  } xb_state_e;

  typedef struct packed {
    logic wr;
    logic mux;
    logic tri_w;
    logic rdy_en;
    logic rdy_async;
  } xb_mode_t;

endpackage

// File: rtl/xbus_rdy_sample.sv
module xbus_rdy_sample #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_n,
  input  logic use_async,
  output logic rdy_act
);
  logic [STAGES-1:0] sync_q;

  // synchronizer chain, reset to the inactive level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], ready_n};
  end

  assign rdy_act = use_async ? ~sync_q[STAGES-1] : ~ready_n;
endmodule

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
  parameter int WAIT_W  = 4,
  parameter int TMO_LIM = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] fixed_w,
  input  logic              in_cmd,
  input  logic              rdy_en,
  input  logic              rdy_act,
  output logic              term,
  output logic              tmo
);
  localparam int TW = $clog2(TMO_LIM + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TMO_LIM - 1);

  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic              smp, miss, cnt_en;

  assign smp    = in_cmd && (wcnt_q == '0);
  assign miss   = smp && rdy_en && !rdy_act;
  assign tmo    = miss && (tcnt_q == T_LAST);
  assign term   = smp && (!miss || tmo);
  assign cnt_en = load || in_cmd;

  always_comb begin
    wcnt_d = wcnt_q;
    tcnt_d = tcnt_q;
    if (load) begin
      wcnt_d = fixed_w;
      tcnt_d = '0;
    end else if (in_cmd && (wcnt_q != '0)) begin
      wcnt_d = wcnt_q - 1'b1;
    end else if (miss && !tmo) begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      tcnt_q <= '0;
    end else if (cnt_en) begin
      wcnt_q <= wcnt_d;
      tcnt_q <= tcnt_d;
    end
  end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  xb_mode_t      mode_in,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          term,
  input  logic          tmo,
  input  logic [DW-1:0] ad_in,
  output logic          load,
  output logic          in_cmd,
  output logic          rdy_en,
  output logic          rdy_async,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  xb_state_e     st_q, st_d;
  xb_mode_t      mode_q, mode_sel;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q, ado_q, ado_d;
  logic          ale_q, rdn_q, wrn_q, oe_q, done_q, err_q;
  logic          ale_d, rdn_d, wrn_d, oe_d, strobe_d;
  logic          acc, cap_rd;

  assign req_ready = (st_q == XB_IDLE);
  assign acc       = req_ready && req_valid;
  assign load      = acc;
  assign in_cmd    = (st_q == XB_CMD);
  assign mode_sel  = acc ? mode_in : mode_q;
  assign cap_rd    = term && !mode_q.wr;

  // next-state decode
  always_comb begin
    st_d = st_q;
    case (st_q)
      XB_IDLE: if (req_valid) st_d = mode_in.mux ? XB_ALE : XB_CMD;
      XB_ALE:  st_d = XB_CMD;
      XB_CMD:  if (term) st_d = mode_q.mux ? XB_MUXW : (mode_q.tri_w ? XB_TRIW : XB_IDLE);
      XB_MUXW: st_d = mode_q.tri_w ? XB_TRIW : XB_IDLE;
      XB_TRIW: st_d = XB_IDLE;
      default: st_d = XB_IDLE;
    endcase
  end

  // pin values for the coming clock
  always_comb begin
    ale_d    = (st_d == XB_ALE);
    strobe_d = (st_d == XB_CMD);
    rdn_d    = !(strobe_d && !mode_sel.wr);
    wrn_d    = !(strobe_d && mode_sel.wr);
    oe_d     = ale_d || (strobe_d && mode_sel.wr);
    ado_d    = ale_d ? DW'(req_addr) : (acc ? req_wdata : wdat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XB_IDLE;
      ale_q  <= 1'b0;
      rdn_q  <= 1'b1;
      wrn_q  <= 1'b1;
      oe_q   <= 1'b0;
      ado_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ale_q  <= ale_d;
      rdn_q  <= rdn_d;
      wrn_q  <= wrn_d;
      oe_q   <= oe_d;
      ado_q  <= ado_d;
      done_q <= term;
      err_q  <= tmo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (acc) begin
      mode_q <= mode_in;
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdat_q <= '0;
    else if (cap_rd) rdat_q <= ad_in;
  end

  assign rdy_en    = mode_q.rdy_en;
  assign rdy_async = mode_q.rdy_async;
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rdat_q;
  assign ale       = ale_q;
  assign rd_n      = rdn_q;
  assign wr_n      = wrn_q;
  assign addr_out  = addr_q;
  assign ad_out    = ado_q;
  assign ad_oe     = oe_q;
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WAIT_W   = 4,
  parameter int TMO_LIM  = 255,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic              req_mux,
  input  logic              req_trwait,
  input  logic              req_rdy_en,
  input  logic              req_rdy_async,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [AW-1:0]     addr_out,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in,
  input  logic              ready_n
);
  xb_mode_t mode_in;
  logic     load, in_cmd, rdy_en, rdy_async, rdy_act, term, tmo;

  always_comb begin
    mode_in.wr        = req_write;
    mode_in.mux       = req_mux;
    mode_in.tri_w     = req_trwait;
    mode_in.rdy_en    = req_rdy_en;
    mode_in.rdy_async = req_rdy_async;
  end

  xbus_rdy_sample #(.STAGES(SYNC_STG)) u_smp (
    .clk(clk), .rst_n(rst_n), .ready_n(ready_n),
    .use_async(rdy_async), .rdy_act(rdy_act)
  );

  xbus_wait_ctr #(.WAIT_W(WAIT_W), .TMO_LIM(TMO_LIM)) u_wctr (
    .clk(clk), .rst_n(rst_n), .load(load), .fixed_w(req_wait),
    .in_cmd(in_cmd), .rdy_en(rdy_en), .rdy_act(rdy_act),
    .term(term), .tmo(tmo)
  );

  xbus_cycle_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mode_in(mode_in), .req_addr(req_addr), .req_wdata(req_wdata),
    .term(term), .tmo(tmo), .ad_in(ad_in),
    .load(load), .in_cmd(in_cmd), .rdy_en(rdy_en), .rdy_async(rdy_async),
    .done(done), .err(err), .rdata(rdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .addr_out(addr_out), .ad_out(ad_out), .ad_oe(ad_oe)
  );
endmodule

// File: rtl/xbus_cycle_chk.sv
module xbus_cycle_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic done,
  input logic err
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));                                            // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !ale));                         // R2
  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);                                                 // R3
  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!rd_n || !wr_n));                                     // R3
  AST_ALE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);                                                // R3
  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);                                              // R12
  AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);                                             // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);                                                 // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                               // R11
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n));             // R11
endmodule

bind xbus_cycle_ctrl xbus_cycle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .done(done), .err(err)
);

// File: tb/tb_xbus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_cycle_ctrl;
  localparam int AW = 16, DW = 16, WAIT_W = 3, TMO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0, req_mux = 1'b0;
  logic              req_trwait = 1'b0, req_rdy_en = 1'b0, req_rdy_async = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0, ad_in = '0;
  logic [WAIT_W-1:0] req_wait = '0;
  logic              ready_n = 1'b1;
  logic              req_ready, done, err, ale, rd_n, wr_n, ad_oe;
  logic [DW-1:0]     rdata, ad_out;
  logic [AW-1:0]     addr_out;

  xbus_cycle_ctrl #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W), .TMO_LIM(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wait(req_wait), .req_mux(req_mux), .req_trwait(req_trwait),
    .req_rdy_en(req_rdy_en), .req_rdy_async(req_rdy_async),
    .done(done), .err(err), .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .addr_out(addr_out), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ready_n(ready_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 latch, 2 strobe, 3 settle, 4 turnaround
  int            m_ph, m_w, m_t;
  bit            m_wr, m_mx, m_tr, m_re, m_as, fin, to, act, h1, h2;
  bit            e_done, e_err;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, e_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_w = 0; m_t = 0; h1 = 1'b1; h2 = 1'b1;
      m_wr = 1'b0; m_mx = 1'b0; m_tr = 1'b0; m_re = 1'b0; m_as = 1'b0;
      e_done = 1'b0; e_err = 1'b0; e_rdata = '0; m_addr = '0; m_wd = '0;
    end else begin
      fin = 1'b0; to = 1'b0;
      act = m_as ? !h2 : !ready_n;
      case (m_ph)
        0: if (req_valid) begin
             m_wr = req_write; m_mx = req_mux; m_tr = req_trwait;
             m_re = req_rdy_en; m_as = req_rdy_async;
             m_addr = req_addr; m_wd = req_wdata;
             m_w = int'(req_wait); m_t = 0;
             m_ph = req_mux ? 1 : 2;
           end
        1: m_ph = 2;
        2: begin
             if (m_w > 0) m_w--;
             else if (!m_re || act) fin = 1'b1;
             else if (m_t == TMO - 1) begin fin = 1'b1; to = 1'b1; end
             else m_t++;
             if (fin) m_ph = m_mx ? 3 : (m_tr ? 4 : 0);
           end
        3: m_ph = m_tr ? 4 : 0;
        default: m_ph = 0;
      endcase
      e_done = fin;
      e_err  = to;
      if (fin && !m_wr) e_rdata = ad_in;
      h2 = h1;
      h1 = ready_n;
    end
  end

  // clock-by-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(req_ready === (m_ph == 0), "R2 req_ready", 32'(req_ready), 32'(m_ph == 0));
      chk(ale === (m_ph == 1), "R3 ale", 32'(ale), 32'(m_ph == 1));
      chk(addr_out === m_addr, "R3 addr_out", 32'(addr_out), 32'(m_addr));
      chk(rd_n === !(m_ph == 2 && !m_wr), "R4 rd_n", 32'(rd_n), 32'(!(m_ph == 2 && !m_wr)));
      chk(wr_n === !(m_ph == 2 && m_wr), "R4 wr_n", 32'(wr_n), 32'(!(m_ph == 2 && m_wr)));
      chk(ad_oe === (m_ph == 1 || (m_ph == 2 && m_wr)), "R12 ad_oe", 32'(ad_oe),
          32'(m_ph == 1 || (m_ph == 2 && m_wr)));
      if (m_ph == 1)
        chk(ad_out === m_addr, "R3 ad_out address", 32'(ad_out), 32'(m_addr));
      if (m_ph == 2 && m_wr)
        chk(ad_out === m_wd, "R12 ad_out data", 32'(ad_out), 32'(m_wd));
      chk(done === e_done, "R11 done", 32'(done), 32'(e_done));
      chk(err === e_err, "R10 err", 32'(err), 32'(e_err));
      chk(rdata === e_rdata, "R11 rdata", 32'(rdata), 32'(e_rdata));
    end
  end

  // one transfer; exp_len < 0 skips the strobe length check
  task automatic run_txn(input bit wr, input bit mx, input bit tr, input bit re,
                         input bit as, input int w, input int d,
                         input logic [15:0] a, input logic [15:0] dt,
                         input int exp_len, input int exp_gap, input string tag);
    int len, gap;
    len = 0; gap = 0;
    req_valid = 1'b1; req_write = wr; req_mux = mx; req_trwait = tr;
    req_rdy_en = re; req_rdy_async = as; req_wait = WAIT_W'(w);
    req_addr = a; req_wdata = dt; ad_in = a ^ 16'h5A3C; ready_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (rd_n && wr_n) begin ready_n = 1'b1; @(negedge clk); end
    while (!rd_n || !wr_n) begin
      ready_n = !(len >= w + d);
      len++;
      @(negedge clk);
    end
    ready_n = 1'b1;
    while (!req_ready) begin gap++; @(negedge clk); end
    if (exp_len >= 0) chk(len == exp_len, {tag, " strobe length"}, 32'(len), 32'(exp_len));
    chk(gap == exp_gap, "R9 post-transfer gap", 32'(gap), 32'(exp_gap));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin ready_n = 1'b1; @(negedge clk); end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk(ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1, "R1 strobes in reset",
        32'({ale, rd_n, wr_n}), 32'(3'b011));
    chk(ad_oe === 1'b0 && done === 1'b0 && err === 1'b0, "R1 flags in reset",
        32'({ad_oe, done, err}), 32'(3'b000));
    chk(req_ready === 1'b1, "R1 req_ready in reset", 32'(req_ready), 32'(1));
    rst_n = 1'b1;
    idle(2);
    // R5: length fixed by wait count, pin ignored
    run_txn(0, 0, 0, 0, 0, 0, 50, 16'h1234, 16'h0000, 1, 0, "R5");
    idle(3);
    run_txn(1, 0, 0, 0, 0, 3, 50, 16'h2468, 16'hBEEF, 4, 0, "R5");
    idle(3);
    // R3/R8: multiplexed read and write
    run_txn(0, 1, 0, 0, 0, 2, 50, 16'hA0A1, 16'h0000, 3, 1, "R8");
    idle(3);
    run_txn(1, 1, 1, 0, 0, 1, 50, 16'hC3C3, 16'h7E81, 2, 2, "R9");
    idle(3);
    run_txn(0, 0, 1, 0, 0, 0, 50, 16'h0F0F, 16'h0000, 1, 1, "R9");
    idle(3);
    // R6: pin sampled directly
    run_txn(0, 0, 0, 1, 0, 1, 3, 16'h4321, 16'h0000, 5, 0, "R6");
    idle(3);
    run_txn(1, 1, 0, 1, 0, 0, 0, 16'h5555, 16'h1357, 1, 1, "R6");
    idle(3);
    // R7: through the synchronizer chain
    run_txn(0, 0, 0, 1, 1, 0, 0, 16'h6677, 16'h0000, 3, 0, "R7");
    idle(3);
    run_txn(1, 1, 0, 1, 1, 2, 1, 16'h8899, 16'h2244, 6, 1, "R7");
    idle(3);
    run_txn(0, 0, 0, 1, 1, 0, 0, 16'h1111, 16'h0000, 3, 0, "R7");
    run_txn(0, 0, 0, 1, 1, 0, 5, 16'h2222, 16'h0000, 1, 0, "R7 stale low");
    run_txn(1, 0, 1, 1, 0, 0, 0, 16'h3333, 16'h9999, 1, 1, "R6");
    idle(3);
    // R10: handshake never arrives
    run_txn(0, 0, 0, 1, 0, 1, 100, 16'hDEAD, 16'h0000, 1 + TMO, 0, "R10");
    idle(3);
    run_txn(1, 1, 1, 1, 1, 0, 100, 16'hFACE, 16'h0C0C, TMO, 2, "R10");
    idle(3);
    summary();
  end
endmodule